// File: doc/BRIEF.md
# SIMD Instruction Fault Checker

This block decides whether a 128-bit SIMD instruction may go ahead or must be stopped with a fault. When the issue stage raises a one-cycle check request, the block looks at three control-register enable bits, the instruction's feature-present flag, a lock-prefix flag, whether the instruction has a memory operand, that operand's address, and whether the core is in real-address mode.

One clock later the block presents its verdict. The verdict is a one-hot fault code: no fault, invalid opcode, device not available, or general protection. A strobe pulses with the code whenever the code names a fault. The code then holds until the next request.

The invalid-opcode causes come from the enable bits, the feature flag and the lock prefix. A pending task switch gives device-not-available. A memory operand that is not aligned to the operand size, or that runs past the real-mode address ceiling, gives general protection. When several faults apply at once, a fixed priority picks the one that is reported.

Top module: `simd_fault_gate`

## Requirements
- R1: After reset, and until the first request completes, `fault_code` is 4'b0001 (no fault) and `fault_vld` is 0. The code encoding is: bit 0 no fault, bit 1 invalid opcode, bit 2 device not available, bit 3 general protection.
- R2: The emulation enable (control register 0, bit 2, on `cr0_em`) at 1 gives invalid opcode.
- R3: The OS save/restore support bit (control register 4, bit 9, on `cr4_osfx`) at 0 gives invalid opcode.
- R4: `feat_present` at 0 gives invalid opcode.
- R5: `lock_pfx` at 1 always gives invalid opcode.
- R6: The task-switched bit (control register 0, bit 3, on `cr0_ts`) at 1 gives device not available.
- R7: A memory operand whose address is not a multiple of 16 (any of `mem_addr[3:0]` nonzero) gives general protection in both modes.
- R8: In real mode, a memory operand with `mem_addr + 15 > 0xFFFF` gives general protection. In protected mode no range check is made.
- R9: When several faults apply, invalid opcode is reported first, then device not available, then general protection.
- R10: When `mem_op` is 0 the address is ignored, so no general-protection fault is raised whatever `mem_addr` holds.
- R11: The code appears in the cycle after `chk_req`. `fault_vld` is high for that single cycle exactly when the code is not "no fault". Without a request the code holds and `fault_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req | input | 1 | One-cycle request to evaluate the present inputs |
| cr0_ts | input | 1 | Task-switched bit of control register 0 |
| cr0_em | input | 1 | Emulation bit of control register 0 |
| cr4_osfx | input | 1 | OS save/restore support bit of control register 4 |
| feat_present | input | 1 | The SIMD feature is implemented |
| lock_pfx | input | 1 | The instruction carries a lock prefix |
| mem_op | input | 1 | The source operand is in memory |
| mem_addr | input | ADDR_W | Effective address of the memory operand |
| real_mode | input | 1 | 1 = real-address mode, 0 = protected mode |
| fault_code | output | 4 | One-hot verdict, registered |
| fault_vld | output | 1 | Pulses with a code that names a fault |

## Verification
The hardest case to reach is where the priority decides the outcome: an address that is both misaligned and beyond the real-mode ceiling, or a general-protection condition that is masked by an invalid-opcode or device-not-available cause. The bench sweeps all 128 combinations of the seven single-bit conditions. Each combination is crossed with six addresses chosen to sit on each side of the alignment and ceiling boundaries, including `0xFFF0` (the last legal address) and `0xFFF1` (misaligned and past the ceiling). Between requests the inputs are switched to an all-fault pattern, which shows whether the held code and the strobe really ignore inputs that arrive without a request.

// File: rtl/simd_fault_pkg.sv
package simd_fault_pkg;

  // One-hot verdict encoding
  typedef enum logic [3:0] {
    FC_NONE = 4'b0001,
    FC_UD   = 4'b0010,
    FC_NM   = 4'b0100,
    FC_GP   = 4'b1000
  } fault_code_e;

  localparam int FC_W = 4;

  // Number of independent invalid-opcode causes
  localparam int UD_CAUSES = 4;

endpackage

// File: rtl/simd_ud_check.sv
module simd_ud_check
  import simd_fault_pkg::*;
(
  input  logic cr0_ts,
  input  logic cr0_em,
  input  logic cr4_osfx,
  input  logic feat_present,
  input  logic lock_pfx,
  output logic ud_hit,
  output logic nm_hit
);

  logic [UD_CAUSES-1:0] cause;

  always_comb begin
    cause[0] = cr0_em;
    cause[1] = ~cr4_osfx;
    cause[2] = ~feat_present;
    cause[3] = lock_pfx;
  end

  assign ud_hit = |cause;
  assign nm_hit = cr0_ts;

endmodule

// File: rtl/simd_mem_check.sv
module simd_mem_check #(
  parameter int          ADDR_W     = 32,
  parameter int          OP_BYTES   = 16,
  parameter int unsigned REAL_LIMIT = 32'h0000_FFFF
) (
  input  logic              mem_op,
  input  logic              real_mode,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              gp_hit
);

  localparam int OFS_W = (OP_BYTES > 1) ? $clog2(OP_BYTES) : 1;
  localparam int EXT_W = ADDR_W + 1;
  localparam logic [EXT_W-1:0] LIMIT_X = EXT_W'(REAL_LIMIT);
  localparam logic [EXT_W-1:0] SPAN_X  = EXT_W'(OP_BYTES - 1);

  logic             misaligned;
  logic             over_limit;
  logic [EXT_W-1:0] last_byte;

  generate
    if (OP_BYTES > 1) begin : g_align
      assign misaligned = |mem_addr[OFS_W-1:0];
    end else begin : g_noalign
      assign misaligned = 1'b0;
    end
  endgenerate

  assign last_byte  = {1'b0, mem_addr} + SPAN_X;
  assign over_limit = real_mode && (last_byte > LIMIT_X);
  assign gp_hit     = mem_op && (misaligned || over_limit);

endmodule

// File: rtl/simd_fault_prio.sv
module simd_fault_prio
  import simd_fault_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            chk_req,
  input  logic            ud_hit,
  input  logic            nm_hit,
  input  logic            gp_hit,
  output logic [FC_W-1:0] fault_code,
  output logic            fault_vld
);

  fault_code_e pick;
  fault_code_e code_q;
  logic        vld_q;

  always_comb begin
    if (ud_hit)      pick = FC_UD;
    else if (nm_hit) pick = FC_NM;
    else if (gp_hit) pick = FC_GP;
    else             pick = FC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= FC_NONE;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= chk_req && (pick != FC_NONE);
      if (chk_req) code_q <= pick;
    end
  end

  assign fault_code = code_q;
  assign fault_vld  = vld_q;

  p_code_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(fault_code) == 1);

  p_ud_first_r9: assert property (@(posedge clk) disable iff (rst)
    chk_req && ud_hit |=> fault_code == FC_UD);

  p_nm_over_gp_r9: assert property (@(posedge clk) disable iff (rst)
    chk_req && !ud_hit && nm_hit |=> fault_code == FC_NM);

  p_vld_after_req_r11: assert property (@(posedge clk) disable iff (rst)
    fault_vld |-> $past(chk_req));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !chk_req |=> $stable(fault_code));

endmodule

// File: rtl/simd_fault_gate.sv
module simd_fault_gate
  import simd_fault_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          OP_BYTES   = 16,
  parameter int unsigned REAL_LIMIT = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_req,
  input  logic              cr0_ts,
  input  logic              cr0_em,
  input  logic              cr4_osfx,
  input  logic              feat_present,
  input  logic              lock_pfx,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              real_mode,
  output logic [FC_W-1:0]   fault_code,
  output logic              fault_vld
);

  logic ud_hit, nm_hit, gp_hit;

  simd_ud_check u_ud (
    .cr0_ts       (cr0_ts),
    .cr0_em       (cr0_em),
    .cr4_osfx     (cr4_osfx),
    .feat_present (feat_present),
    .lock_pfx     (lock_pfx),
    .ud_hit       (ud_hit),
    .nm_hit       (nm_hit)
  );

  simd_mem_check #(
    .ADDR_W     (ADDR_W),
    .OP_BYTES   (OP_BYTES),
    .REAL_LIMIT (REAL_LIMIT)
  ) u_mem (
    .mem_op    (mem_op),
    .real_mode (real_mode),
    .mem_addr  (mem_addr),
    .gp_hit    (gp_hit)
  );

  simd_fault_prio u_prio (
    .clk        (clk),
    .rst        (rst),
    .chk_req    (chk_req),
    .ud_hit     (ud_hit),
    .nm_hit     (nm_hit),
    .gp_hit     (gp_hit),
    .fault_code (fault_code),
    .fault_vld  (fault_vld)
  );

  p_lock_ud_r5: assert property (@(posedge clk) disable iff (rst)
    chk_req && lock_pfx |=> fault_code == FC_UD);

  p_emu_ud_r2: assert property (@(posedge clk) disable iff (rst)
    chk_req && cr0_em |=> fault_code == FC_UD);

  p_osfx_ud_r3: assert property (@(posedge clk) disable iff (rst)
    chk_req && !cr4_osfx |=> fault_code == FC_UD);

  p_feat_ud_r4: assert property (@(posedge clk) disable iff (rst)
    chk_req && !feat_present |=> fault_code == FC_UD);

  p_ts_fault_r6: assert property (@(posedge clk) disable iff (rst)
    chk_req && cr0_ts |=> fault_code != FC_NONE);

  p_reg_no_gp_r10: assert property (@(posedge clk) disable iff (rst)
    chk_req && !mem_op |=> fault_code != FC_GP);

  p_misalign_r7: assert property (@(posedge clk) disable iff (rst)
    chk_req && mem_op && (mem_addr[3:0] != 4'd0) |=> fault_code != FC_NONE);

endmodule

// File: tb/simd_fault_gate_tb.sv
module simd_fault_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic              chk_req;
  logic              cr0_ts, cr0_em, cr4_osfx, feat_present, lock_pfx, mem_op, real_mode;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        fault_code;
  logic              fault_vld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_fault_gate #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .chk_req(chk_req), .cr0_ts(cr0_ts), .cr0_em(cr0_em),
    .cr4_osfx(cr4_osfx), .feat_present(feat_present), .lock_pfx(lock_pfx),
    .mem_op(mem_op), .mem_addr(mem_addr), .real_mode(real_mode),
    .fault_code(fault_code), .fault_vld(fault_vld)
  );

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b (ts=%0b em=%0b osfx=%0b feat=%0b lock=%0b mem=%0b real=%0b addr=%h)",
               tag, got, exp, cr0_ts, cr0_em, cr4_osfx, feat_present, lock_pfx, mem_op, real_mode, mem_addr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got=hang exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic [ADDR_W-1:0] addrs [6];

  initial begin
    addrs[0] = 32'h0000_0100;
    addrs[1] = 32'h0000_0104;
    addrs[2] = 32'h0000_FFF0;
    addrs[3] = 32'h0000_FFF1;
    addrs[4] = 32'h0001_0000;
    addrs[5] = 32'h0000_FFE8;

    rst = 1'b1; chk_req = 1'b0;
    cr0_ts = 0; cr0_em = 0; cr4_osfx = 1; feat_present = 1; lock_pfx = 0;
    mem_op = 0; real_mode = 0; mem_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 reset code", fault_code, 4'b0001);
    check("R1 reset vld", {3'b0, fault_vld}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle code", fault_code, 4'b0001);
    check("R1 idle vld", {3'b0, fault_vld}, 4'b0000);

    for (int c = 0; c < 128; c++) begin
      for (int a = 0; a < 6; a++) begin
        logic ud, nm, mis, ovr, gp, badaddr;
        logic [3:0] exp;
        string tag;
        cr0_ts       = c[0];
        cr0_em       = c[1];
        cr4_osfx     = c[2];
        feat_present = c[3];
        lock_pfx     = c[4];
        mem_op       = c[5];
        real_mode    = c[6];
        mem_addr     = addrs[a];
        chk_req      = 1'b1;

        ud      = cr0_em | ~cr4_osfx | ~feat_present | lock_pfx;
        nm      = cr0_ts;
        mis     = (mem_addr % 16) != 0;
        ovr     = real_mode && (({1'b0, mem_addr} + 33'd15) > 33'h0_0000_FFFF);
        badaddr = mis | ovr;
        gp      = mem_op & badaddr;
        exp     = ud ? 4'b0010 : nm ? 4'b0100 : gp ? 4'b1000 : 4'b0001;

        if (ud && (nm || gp))      tag = "R9 ud wins";
        else if (cr0_em)           tag = "R2 emulation";
        else if (!cr4_osfx)        tag = "R3 os support";
        else if (!feat_present)    tag = "R4 feature";
        else if (lock_pfx)         tag = "R5 lock";
        else if (nm && gp)         tag = "R9 nm wins";
        else if (nm)               tag = "R6 task switched";
        else if (!mem_op)          tag = "R10 register operand";
        else if (mis)              tag = "R7 alignment";
        else if (ovr)              tag = "R8 real limit";
        else                       tag = "R8 in range";

        @(negedge clk);
        check(tag, fault_code, exp);
        check("R11 strobe", {3'b0, fault_vld}, {3'b0, exp != 4'b0001});

        chk_req = 1'b0;
        cr0_em = 1; cr0_ts = 1; lock_pfx = 1; mem_op = 1; mem_addr = 32'h0001_0003;
        @(negedge clk);
        check("R11 strobe drop", {3'b0, fault_vld}, 4'b0000);
        check("R11 hold", fault_code, exp);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule